// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control unit for a 32-bit multi-cycle processor whose instruction and data accesses share one memory port. It is a Moore state machine: every control output depends only on the current step. It walks each instruction through a fixed series of steps: fetch, decode and register read, execute or address computation, memory access, and register write-back. The opcode of the instruction being run is the only data input. It steers the machine once at decode and, for memory instructions, once more after the address has been computed.

The instruction set covered is register-register arithmetic, word load, word store, branch-on-equal, unconditional jump and load-upper-immediate. Load-upper-immediate has its own completion step. That step writes the immediate, shifted into the upper half, straight to the target register through a third code on the write-data select. The path adds no ALU cycle. Opcodes outside this set are dropped at decode, and the machine returns to fetch.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A rising clock edge with `rst_n` low puts the machine in the fetch step, whatever step it was in. The outputs show the fetch vector in the following cycle.
- R2: The fetch step asserts `mem_rd`, `ir_we` and `pc_we`, with `addr_sel_data`=0, `alu_a_sel`=0, `alu_b_sel`=01 (constant 4), `alu_op`=00 (add) and `pc_src`=00 (ALU result). The decode step always follows.
- R3: The decode step sets `alu_a_sel`=0, `alu_b_sel`=11 (shifted immediate) and `alu_op`=00. Its successor depends on the opcode:
  - 000000 goes to execute.
  - 100011 and 101011 go to address.
  - 000100 goes to branch.
  - 000010 goes to jump.
  - 001111 goes to upper-immediate.
  - Any other opcode goes back to fetch.
- R4: The address step sets `alu_a_sel`=1, `alu_b_sel`=10 (sign-extended immediate) and `alu_op`=00. It moves to the store step for opcode 101011 and to the read step otherwise.
- R5: The read step asserts `mem_rd` with `addr_sel_data`=1 and moves to load write-back. Load write-back asserts `rf_we` with `rf_dst_rd`=0 (rt) and `wb_sel`=01 (memory data register).
- R6: The store step asserts `mem_wr` with `addr_sel_data`=1.
- R7: The execute step sets `alu_a_sel`=1, `alu_b_sel`=00 (B register) and `alu_op`=10 (function field), then moves to register write-back. Register write-back asserts `rf_we` with `rf_dst_rd`=1 (rd) and `wb_sel`=00 (ALU output register).
- R8: The branch step sets `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=01 (subtract), and asserts `pc_we_cond` with `pc_src`=01 (ALU output register).
- R9: The jump step asserts `pc_we` with `pc_src`=10 (jump address).
- R10: The upper-immediate step asserts `rf_we` with `rf_dst_rd`=0 and `wb_sel`=10 (immediate shifted left by 16).
- R11: Any output a step does not name is 0 in that step. `mem_rd` and `mem_wr` are never high together.
- R12: These steps return to fetch on the next clock: load write-back, store, register write-back, branch, jump and upper-immediate. Counting the fetch cycle, an instruction takes this many cycles:
  - load: 5
  - store: 4
  - register-register: 4
  - branch: 3
  - jump: 3
  - upper-immediate: 3
  - undefined opcode: 2

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_we | output | 1 | Unconditional program counter write |
| pc_we_cond | output | 1 | Program counter write if the ALU zero flag is set |
| addr_sel_data | output | 1 | Memory address from ALU output register (1) or PC (0) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| wb_sel | output | 2 | Register write data: 00 ALU output, 01 memory data, 10 upper immediate |
| ir_we | output | 1 | Instruction register load |
| pc_src | output | 2 | Next PC: 00 ALU result, 01 ALU output register, 10 jump address |
| alu_op | output | 2 | ALU control: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU A input: 0 PC, 1 A register |
| alu_b_sel | output | 2 | ALU B input: 00 B register, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| rf_we | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Write destination: 1 rd field, 0 rt field |

## Verification
The bench builds the sequencer with its default 6-bit opcode width and default opcode assignments, passing them explicitly. Drawing opcodes uniformly from the 64 codes of that width covers every undefined code on the fall-back path next to the six decoded ones. Keeping the opcode field narrow lets random draws reach every dispatch arm many times. Short resets land in random steps, including within memory instructions, so the forced return to fetch is exercised from every state.

// File: rtl/mc_ctrl_pkg.sv
// Shared types for the multi-cycle control sequencer.
// Assumes: binary-encoded step numbers; the values of the control fields
// are fixed by the datapath multiplexers they drive.
package mc_ctrl_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDMEM  = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STMEM  = 4'd5,
        ST_EXEC   = 4'd6,
        ST_RWB    = 4'd7,
        ST_BRANCH = 4'd8,
        ST_JUMP   = 4'd9,
        ST_LUI    = 4'd10
    } state_e;

    typedef enum logic [2:0] {
        CLS_RTYPE,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH,
        CLS_JUMP,
        CLS_LUI,
        CLS_NONE
    } op_class_e;

    localparam logic [1:0] WB_ALUOUT = 2'b00;
    localparam logic [1:0] WB_MDR    = 2'b01;
    localparam logic [1:0] WB_UPPER  = 2'b10;

    localparam logic [1:0] SRCB_REG   = 2'b00;
    localparam logic [1:0] SRCB_FOUR  = 2'b01;
    localparam logic [1:0] SRCB_IMM   = 2'b10;
    localparam logic [1:0] SRCB_IMMSH = 2'b11;

    localparam logic [1:0] PCS_ALU    = 2'b00;
    localparam logic [1:0] PCS_ALUOUT = 2'b01;
    localparam logic [1:0] PCS_JUMP   = 2'b10;

    localparam logic [1:0] AOP_ADD    = 2'b00;
    localparam logic [1:0] AOP_SUB    = 2'b01;
    localparam logic [1:0] AOP_FUNCT  = 2'b10;

    typedef struct packed {
        logic       pc_we;
        logic       pc_we_cond;
        logic       addr_sel_data;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_we;
        logic       rf_we;
        logic       rf_dst_rd;
        logic       alu_a_sel;
        logic [1:0] wb_sel;
        logic [1:0] pc_src;
        logic [1:0] alu_op;
        logic [1:0] alu_b_sel;
    } ctrl_t;

endpackage

// File: rtl/mc_ctrl_classify.sv
// Opcode classifier: maps the opcode field to an instruction class.
// Assumes: the opcode holds steady for the whole instruction (it comes from
// the instruction register); codes that match no parameter are CLS_NONE.
module mc_ctrl_classify
    import mc_ctrl_pkg::*;
#(
    parameter int                OP_W      = 6,
    parameter logic [OP_W-1:0]   RTYPE_OP  = 6'b000000,
    parameter logic [OP_W-1:0]   LOAD_OP   = 6'b100011,
    parameter logic [OP_W-1:0]   STORE_OP  = 6'b101011,
    parameter logic [OP_W-1:0]   BRANCH_OP = 6'b000100,
    parameter logic [OP_W-1:0]   JUMP_OP   = 6'b000010,
    parameter logic [OP_W-1:0]   LUI_OP    = 6'b001111
) (
    input  logic [OP_W-1:0] opcode,
    output op_class_e       cls
);

    // Compare the opcode against each decoded code in turn.
    always_comb begin
        if (opcode == RTYPE_OP)       cls = CLS_RTYPE;
        else if (opcode == LOAD_OP)   cls = CLS_LOAD;
        else if (opcode == STORE_OP)  cls = CLS_STORE;
        else if (opcode == BRANCH_OP) cls = CLS_BRANCH;
        else if (opcode == JUMP_OP)   cls = CLS_JUMP;
        else if (opcode == LUI_OP)    cls = CLS_LUI;
        else                          cls = CLS_NONE;
    end

endmodule

// File: rtl/mc_ctrl_seq.sv
// Step register and next-step logic of the control sequencer.
// Assumes: synchronous active-low reset; the class input is only consulted
// in the decode and address steps.
module mc_ctrl_seq
    import mc_ctrl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  op_class_e cls,
    output state_e    state
);

    state_e state_nxt;

    // Choose the following step from the current step and instruction class.
    always_comb begin
        unique case (state)
            ST_FETCH:  state_nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (cls)
                    CLS_RTYPE:  state_nxt = ST_EXEC;
                    CLS_LOAD:   state_nxt = ST_ADDR;
                    CLS_STORE:  state_nxt = ST_ADDR;
                    CLS_BRANCH: state_nxt = ST_BRANCH;
                    CLS_JUMP:   state_nxt = ST_JUMP;
                    CLS_LUI:    state_nxt = ST_LUI;
                    default:    state_nxt = ST_FETCH;
                endcase
            end
            ST_ADDR:   state_nxt = (cls == CLS_STORE) ? ST_STMEM : ST_LDMEM;
            ST_LDMEM:  state_nxt = ST_LDWB;
            ST_EXEC:   state_nxt = ST_RWB;
            default:   state_nxt = ST_FETCH;
        endcase
    end

    // Hold the current step; reset forces fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH;
        end else begin
            state <= state_nxt;
        end
    end

endmodule

// File: rtl/mc_ctrl_outputs.sv
// Moore output decoder: one control vector per step.
// Assumes: every field not set for a step stays at zero.
module mc_ctrl_outputs
    import mc_ctrl_pkg::*;
(
    input  state_e state,
    output ctrl_t  ctrl
);

    // Produce the control vector of the current step.
    always_comb begin
        ctrl = '0;
        unique case (state)
            ST_FETCH: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.ir_we     = 1'b1;
                ctrl.pc_we     = 1'b1;
                ctrl.alu_b_sel = SRCB_FOUR;
                ctrl.alu_op    = AOP_ADD;
                ctrl.pc_src    = PCS_ALU;
            end
            ST_DECODE: begin
                ctrl.alu_b_sel = SRCB_IMMSH;
                ctrl.alu_op    = AOP_ADD;
            end
            ST_ADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = SRCB_IMM;
                ctrl.alu_op    = AOP_ADD;
            end
            ST_LDMEM: begin
                ctrl.mem_rd        = 1'b1;
                ctrl.addr_sel_data = 1'b1;
            end
            ST_LDWB: begin
                ctrl.rf_we  = 1'b1;
                ctrl.wb_sel = WB_MDR;
            end
            ST_STMEM: begin
                ctrl.mem_wr        = 1'b1;
                ctrl.addr_sel_data = 1'b1;
            end
            ST_EXEC: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = SRCB_REG;
                ctrl.alu_op    = AOP_FUNCT;
            end
            ST_RWB: begin
                ctrl.rf_we     = 1'b1;
                ctrl.rf_dst_rd = 1'b1;
                ctrl.wb_sel    = WB_ALUOUT;
            end
            ST_BRANCH: begin
                ctrl.alu_a_sel  = 1'b1;
                ctrl.alu_b_sel  = SRCB_REG;
                ctrl.alu_op     = AOP_SUB;
                ctrl.pc_we_cond = 1'b1;
                ctrl.pc_src     = PCS_ALUOUT;
            end
            ST_JUMP: begin
                ctrl.pc_we  = 1'b1;
                ctrl.pc_src = PCS_JUMP;
            end
            ST_LUI: begin
                ctrl.rf_we  = 1'b1;
                ctrl.wb_sel = WB_UPPER;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/mc_ctrl_fsm.sv
// Top of the multi-cycle control sequencer: classifier, step register and
// output decoder wired together, control vector flattened onto ports.
// Assumes: opcode comes from the instruction register and is stable after fetch.
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter int              OP_W      = 6,
    parameter logic [OP_W-1:0] RTYPE_OP  = 6'b000000,
    parameter logic [OP_W-1:0] LOAD_OP   = 6'b100011,
    parameter logic [OP_W-1:0] STORE_OP  = 6'b101011,
    parameter logic [OP_W-1:0] BRANCH_OP = 6'b000100,
    parameter logic [OP_W-1:0] JUMP_OP   = 6'b000010,
    parameter logic [OP_W-1:0] LUI_OP    = 6'b001111
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    output logic            pc_we,
    output logic            pc_we_cond,
    output logic            addr_sel_data,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [1:0]      wb_sel,
    output logic            ir_we,
    output logic [1:0]      pc_src,
    output logic [1:0]      alu_op,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic            rf_we,
    output logic            rf_dst_rd
);

    op_class_e cls;
    state_e    state;
    ctrl_t     ctrl;

    mc_ctrl_classify #(
        .OP_W      (OP_W),
        .RTYPE_OP  (RTYPE_OP),
        .LOAD_OP   (LOAD_OP),
        .STORE_OP  (STORE_OP),
        .BRANCH_OP (BRANCH_OP),
        .JUMP_OP   (JUMP_OP),
        .LUI_OP    (LUI_OP)
    ) u_classify (
        .opcode (opcode),
        .cls    (cls)
    );

    mc_ctrl_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .cls   (cls),
        .state (state)
    );

    mc_ctrl_outputs u_outputs (
        .state (state),
        .ctrl  (ctrl)
    );

    // Flatten the control vector onto the output ports.
    always_comb begin
        pc_we         = ctrl.pc_we;
        pc_we_cond    = ctrl.pc_we_cond;
        addr_sel_data = ctrl.addr_sel_data;
        mem_rd        = ctrl.mem_rd;
        mem_wr        = ctrl.mem_wr;
        wb_sel        = ctrl.wb_sel;
        ir_we         = ctrl.ir_we;
        pc_src        = ctrl.pc_src;
        alu_op        = ctrl.alu_op;
        alu_a_sel     = ctrl.alu_a_sel;
        alu_b_sel     = ctrl.alu_b_sel;
        rf_we         = ctrl.rf_we;
        rf_dst_rd     = ctrl.rf_dst_rd;
    end

endmodule

// File: rtl/mc_ctrl_fsm_checker.sv
// Port-level protocol checks for the control sequencer, bound to its top.
// Assumes: the decode step is the only one driving alu_b_sel = 11.
module mc_ctrl_fsm_checker #(
    parameter int              OP_W     = 6,
    parameter logic [OP_W-1:0] RTYPE_OP = 6'b000000,
    parameter logic [OP_W-1:0] LUI_OP   = 6'b001111
) (
    input logic            clk,
    input logic            rst_n,
    input logic [OP_W-1:0] opcode,
    input logic            pc_we,
    input logic            pc_we_cond,
    input logic            addr_sel_data,
    input logic            mem_rd,
    input logic            mem_wr,
    input logic [1:0]      wb_sel,
    input logic            ir_we,
    input logic [1:0]      pc_src,
    input logic [1:0]      alu_op,
    input logic            alu_a_sel,
    input logic [1:0]      alu_b_sel,
    input logic            rf_we,
    input logic            rf_dst_rd
);

    logic in_decode;
    // Recognise the decode step from its unique B-input select.
    always_comb in_decode = (alu_b_sel == 2'b11);

    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_we |=> (in_decode && !ir_we && !mem_rd));

    assert_decode_rtype_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_decode && opcode == RTYPE_OP) |=> (alu_op == 2'b10 && alu_a_sel));

    assert_decode_lui_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_decode && opcode == LUI_OP) |=> (rf_we && wb_sel == 2'b10 && !rf_dst_rd));

    assert_read_then_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && addr_sel_data) |=> (rf_we && wb_sel == 2'b01 && !rf_dst_rd));

    assert_store_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> ir_we);

    assert_regwrite_returns_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> ir_we);

    assert_branch_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we_cond |-> (pc_src == 2'b01 && alu_op == 2'b01 && !pc_we));

    assert_jump_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pc_src == 2'b10) |=> ir_we);

    assert_mem_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_checker #(
    .OP_W     (OP_W),
    .RTYPE_OP (RTYPE_OP),
    .LUI_OP   (LUI_OP)
) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .opcode        (opcode),
    .pc_we         (pc_we),
    .pc_we_cond    (pc_we_cond),
    .addr_sel_data (addr_sel_data),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .wb_sel        (wb_sel),
    .ir_we         (ir_we),
    .pc_src        (pc_src),
    .alu_op        (alu_op),
    .alu_a_sel     (alu_a_sel),
    .alu_b_sel     (alu_b_sel),
    .rf_we         (rf_we),
    .rf_dst_rd     (rf_dst_rd)
);

// File: tb/mc_ctrl_fsm_bench.sv
// Self-checking bench: a reference step model built from the requirements,
// random and directed opcodes, random short resets.
module mc_ctrl_fsm_bench;

    localparam int              OP_W   = 6;
    localparam logic [OP_W-1:0] OP_R   = 6'b000000;
    localparam logic [OP_W-1:0] OP_LW  = 6'b100011;
    localparam logic [OP_W-1:0] OP_SW  = 6'b101011;
    localparam logic [OP_W-1:0] OP_BEQ = 6'b000100;
    localparam logic [OP_W-1:0] OP_J   = 6'b000010;
    localparam logic [OP_W-1:0] OP_LUI = 6'b001111;
    localparam int              CYCLES = 4000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [OP_W-1:0] opcode = '0;
    logic            pc_we, pc_we_cond, addr_sel_data, mem_rd, mem_wr, ir_we;
    logic            alu_a_sel, rf_we, rf_dst_rd;
    logic [1:0]      wb_sel, pc_src, alu_op, alu_b_sel;

    int errs = 0;
    int checks = 0;

    always #2 clk = ~clk;

    mc_ctrl_fsm #(
        .OP_W (OP_W), .RTYPE_OP (OP_R), .LOAD_OP (OP_LW), .STORE_OP (OP_SW),
        .BRANCH_OP (OP_BEQ), .JUMP_OP (OP_J), .LUI_OP (OP_LUI)
    ) u_mc_ctrl_fsm (
        .clk (clk), .rst_n (rst_n), .opcode (opcode),
        .pc_we (pc_we), .pc_we_cond (pc_we_cond), .addr_sel_data (addr_sel_data),
        .mem_rd (mem_rd), .mem_wr (mem_wr), .wb_sel (wb_sel), .ir_we (ir_we),
        .pc_src (pc_src), .alu_op (alu_op), .alu_a_sel (alu_a_sel),
        .alu_b_sel (alu_b_sel), .rf_we (rf_we), .rf_dst_rd (rf_dst_rd)
    );

    // Expected outputs per step, fields packed as
    // {pc_we,pc_we_cond,iord,mem_rd,mem_wr,ir_we,rf_we,dst,a,wb,pcsrc,aluop,b}.
    function automatic logic [16:0] exp_vec(input int s);
        logic pw = 0, pwc = 0, io = 0, rd = 0, wr = 0, ir = 0, rw = 0, dst = 0, a = 0;
        logic [1:0] wb = 0, ps = 0, op = 0, b = 0;
        case (s)
            0:  begin pw = 1; rd = 1; ir = 1; b = 2'b01; end
            1:  b = 2'b11;
            2:  begin a = 1; b = 2'b10; end
            3:  begin rd = 1; io = 1; end
            4:  begin rw = 1; wb = 2'b01; end
            5:  begin wr = 1; io = 1; end
            6:  begin a = 1; op = 2'b10; end
            7:  begin rw = 1; dst = 1; end
            8:  begin a = 1; op = 2'b01; pwc = 1; ps = 2'b01; end
            9:  begin pw = 1; ps = 2'b10; end
            10: begin rw = 1; wb = 2'b10; end
            default: ;
        endcase
        return {pw, pwc, io, rd, wr, ir, rw, dst, a, wb, ps, op, b};
    endfunction

    // Reference next step.
    function automatic int next_step(input int s, input logic [OP_W-1:0] op, input logic rn);
        if (!rn) return 0;
        case (s)
            0: return 1;
            1: begin
                if (op == OP_R) return 6;
                if (op == OP_LW || op == OP_SW) return 2;
                if (op == OP_BEQ) return 8;
                if (op == OP_J) return 9;
                if (op == OP_LUI) return 10;
                return 0;
            end
            2: return (op == OP_SW) ? 5 : 3;
            3: return 4;
            6: return 7;
            default: return 0;
        endcase
    endfunction

    // Expected instruction length in cycles including fetch (R12).
    function automatic int instr_len(input logic [OP_W-1:0] op);
        if (op == OP_LW) return 5;
        if (op == OP_SW || op == OP_R) return 4;
        if (op == OP_BEQ || op == OP_J || op == OP_LUI) return 3;
        return 2;
    endfunction

    // Requirement tag for the step whose outputs are being checked.
    function automatic string step_req(input int s);
        case (s)
            0: return "R2";  1: return "R3";  2: return "R4";
            3, 4: return "R5";  5: return "R6";  6, 7: return "R7";
            8: return "R8";  9: return "R9";  10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [OP_W-1:0] pick_op();
        int r = $urandom_range(0, 9);
        case (r)
            0: return OP_R;  1: return OP_LW;  2: return OP_SW;
            3: return OP_BEQ; 4: return OP_J;  5: return OP_LUI;
            6: return OP_LW;
            default: return OP_W'($urandom);
        endcase
    endfunction

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [OP_W-1:0] directed [8] = '{OP_R, OP_LW, OP_SW, OP_BEQ, OP_J,
                                          OP_LUI, 6'h3f, 6'h01};
        logic [16:0] act;
        int ms = 0;
        int instr = 0;
        int cnt = 0;
        bit len_ok = 0;
        bit first = 1;
        logic [OP_W-1:0] cur_op = '0;
        void'($urandom(32'h5eed_1234));

        @(posedge clk);
        @(posedge clk);
        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            @(negedge clk);
            act = {pc_we, pc_we_cond, addr_sel_data, mem_rd, mem_wr, ir_we, rf_we,
                   rf_dst_rd, alu_a_sel, wb_sel, pc_src, alu_op, alu_b_sel};
            // R1 after reset, otherwise the step's own requirement; R11 zeros too.
            check(act === exp_vec(ms), first ? "R1" : step_req(ms),
                  $sformatf("outputs in step %0d (R11 zero fields)", ms), act, exp_vec(ms));
            check(!(mem_rd && mem_wr), "R11", "read and write together",
                  {mem_rd, mem_wr}, 0);
            first = !rst_n;
            // R12: cycles between successive fetches.
            if (ir_we) begin
                if (len_ok)
                    check(cnt == instr_len(cur_op), "R12",
                          $sformatf("length of opcode %0h", cur_op), cnt, instr_len(cur_op));
                cnt = 1;
            end else begin
                cnt++;
            end
            // Drive the next stimulus.
            if (ms == 0) begin
                opcode = (instr < 8) ? directed[instr] : pick_op();
                instr++;
                cur_op = opcode;
                len_ok = 1;
            end
            if (instr == 3 && ms == 2) rst_n = 1'b0;
            else if (instr > 8 && $urandom_range(0, 39) == 0) rst_n = 1'b0;
            else rst_n = 1'b1;
            if (!rst_n) begin
                len_ok = 0;
                first = 1;
            end
            ms = next_step(ms, opcode, rst_n);
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule